// File: doc/BRIEF.md
# Cascaded Dual-CRC Frame Generator and Checker

This block protects a fixed-length serial frame with two 16-bit cyclic redundancy checks that are chained together. Bits arrive one per clock on a valid/data pair. A frame starts on a start strobe, and a mode input sampled with that strobe selects what the block does with the frame.

In generate mode, the block passes a 192-bit payload through to a registered output stream. It then emits the first checksum, which uses x^16+x^15+x^2+1 over the payload. After that it emits the second checksum, which uses x^16+x^12+x^5+1 over the payload and the first checksum together. The result is a 224-bit frame. In check mode, the block takes a complete 224-bit frame and reports, for each checksum field, a one-cycle result strobe and a held pass flag. A done strobe closes every frame in both modes.

Both checksum registers start at zero at the start of each frame. Data moves most-significant bit first, and no final inversion is applied. A new start strobe at any point abandons the frame in progress.

Top module: `dual_crc_framer`

## Requirements
- R1: After reset all outputs are 0 and the block is idle. Valid bits presented before the first start strobe produce no output stream, no result strobe and no done strobe.
- R2: The first checksum uses the polynomial 0x8005 (x^16+x^15+x^2+1). Its register is preset to zero and it covers frame bits 0..191, fed MSB first. In generate mode, output bits 192..207 carry it MSB first.
- R3: The second checksum uses the polynomial 0x1021 (x^16+x^12+x^5+1). Its register is preset to zero and it covers frame bits 0..207. In generate mode, output bits 208..223 carry it MSB first.
- R4: mode_i=0 selects generate and mode_i=1 selects check. In generate mode, each accepted bit produces out_vld_o=1 one cycle later. Bits 0..191 are echoed on out_bit_o. bit_i is ignored for bits 192..223. In check mode out_vld_o stays 0.
- R5: In check mode, crc1_chk_o pulses for one cycle, in the cycle after bit 207 is accepted. In that same cycle crc1_ok_o is 1 if and only if bits 192..207 equal the first checksum of bits 0..191. crc1_ok_o then holds until the next start strobe.
- R6: In check mode, crc2_chk_o pulses for one cycle, in the cycle after bit 223 is accepted. In that same cycle crc2_ok_o is 1 if and only if bits 208..223 equal the second checksum of bits 0..207. crc2_ok_o then holds until the next start strobe.
- R7: done_o pulses once per frame, in either mode, in the cycle after bit 223 is accepted.
- R8: A start strobe aborts any frame in progress and resets both checksums. A bit presented in the same cycle as the strobe is bit 0 of the new frame.
- R9: Cycles with bit_valid_i=0 pause the frame without changing it. Valid bits after bit 223 and before the next start strobe are ignored.
- R10: The mode is captured with the start strobe, and changes on mode_i during a frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start strobe; the bit in the same cycle is bit 0 |
| mode_i | input | 1 | 0 = generate, 1 = check; sampled with start_i |
| bit_valid_i | input | 1 | Input bit qualifier |
| bit_i | input | 1 | Serial input bit |
| out_vld_o | output | 1 | Output bit qualifier (generate mode) |
| out_bit_o | output | 1 | Serial output bit |
| crc1_chk_o | output | 1 | First checksum result strobe |
| crc1_ok_o | output | 1 | First checksum pass flag |
| crc2_chk_o | output | 1 | Second checksum result strobe |
| crc2_ok_o | output | 1 | Second checksum pass flag |
| done_o | output | 1 | End-of-frame strobe |

## Verification
Every result of this block is due exactly one clock after the input bit that completes it. The output bit follows its input bit by one cycle. The first result strobe follows bit 207, and the second result strobe and done both follow bit 223. The bench stamps the cycle count at the falling edge where it drives bit 207 and bit 223, and samples all outputs on falling edges. It then requires each strobe to appear exactly one count later and to appear only once. Expected checksums come from a polynomial long division in the bench, and the frames used include all-zero, all-one, alternating and pseudo-random payloads, single-bit corruptions of each field, gaps in the bit stream, and an aborted frame.

// File: rtl/dcrc_pkg.sv
package dcrc_pkg;

   typedef enum logic {
      MODE_GEN = 1'b0,
      MODE_CHK = 1'b1
   } dcrc_mode_e;

   // Decoded frame position for the bit presented this cycle
   typedef struct packed {
      logic accept;   // bit is taken into the frame
      logic cov1;     // bit lies inside the first checksum's coverage
      logic in_f1;    // bit lies in the first checksum field
      logic in_f2;    // bit lies in the second checksum field
      logic last_f1;  // bit is the final bit of the first field
      logic last_f2;  // bit is the final bit of the frame
   } dcrc_pos_t;

endpackage

// File: rtl/dcrc_seq.sv
module dcrc_seq
   import dcrc_pkg::*;
#(
   parameter int PAYLOAD_BITS = 192,
   parameter int CRC_W        = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       mode_i,
   input  logic       bit_valid_i,
   output dcrc_pos_t  pos_o,
   output dcrc_mode_e mode_o
);
   localparam int FRAME_BITS = PAYLOAD_BITS + 2 * CRC_W;
   localparam int F1_END     = PAYLOAD_BITS + CRC_W;
   localparam int POS_W      = $clog2(FRAME_BITS + 1);

   logic [POS_W-1:0] cnt_q;
   logic [POS_W-1:0] pos_eff;
   logic             act_q;
   logic             live;
   dcrc_mode_e       mode_q;

   always_comb begin
      pos_eff = start_i ? '0 : cnt_q;
      live    = start_i | act_q;
      mode_o  = start_i ? dcrc_mode_e'(mode_i) : mode_q;

      pos_o.accept  = bit_valid_i & live;
      pos_o.cov1    = (pos_eff < POS_W'(F1_END));
      pos_o.in_f1   = (pos_eff >= POS_W'(PAYLOAD_BITS)) && (pos_eff < POS_W'(F1_END));
      pos_o.in_f2   = (pos_eff >= POS_W'(F1_END));
      pos_o.last_f1 = (pos_eff == POS_W'(F1_END - 1));
      pos_o.last_f2 = (pos_eff == POS_W'(FRAME_BITS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         act_q  <= 1'b0;
         mode_q <= MODE_GEN;
      end else begin
         if (start_i) begin
            mode_q <= dcrc_mode_e'(mode_i);
         end
         if (pos_o.accept) begin
            if (pos_o.last_f2) begin
               act_q <= 1'b0;
               cnt_q <= '0;
            end else begin
               act_q <= 1'b1;
               cnt_q <= pos_eff + POS_W'(1);
            end
         end else if (start_i) begin
            act_q <= 1'b1;
            cnt_q <= '0;
         end
      end
   end

endmodule

// File: rtl/dcrc_lane.sv
module dcrc_lane #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   POLY = 16'h8005
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic en_i,
   input  logic data_i,
   output logic msb_o,
   output logic zero_o
);
   logic [W-1:0] crc_q;
   logic [W-1:0] base;
   logic [W-1:0] nxt;
   logic         fb;

   always_comb begin
      base   = clear_i ? '0 : crc_q;
      fb     = data_i ^ base[W-1];
      nxt    = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
      msb_o  = base[W-1];
      zero_o = (nxt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '0;
      end else if (en_i) begin
         crc_q <= nxt;
      end else begin
         crc_q <= base;
      end
   end

endmodule

// File: rtl/dcrc_result.sv
module dcrc_result
   import dcrc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  dcrc_pos_t  pos_i,
   input  dcrc_mode_e mode_i,
   input  logic       data_i,
   input  logic       zero1_i,
   input  logic       zero2_i,
   output logic       out_vld_o,
   output logic       out_bit_o,
   output logic       crc1_chk_o,
   output logic       crc1_ok_o,
   output logic       crc2_chk_o,
   output logic       crc2_ok_o,
   output logic       done_o
);
   logic is_chk;
   logic end1;
   logic end2;

   always_comb begin
      is_chk = (mode_i == MODE_CHK);
      end1   = pos_i.accept & pos_i.last_f1;
      end2   = pos_i.accept & pos_i.last_f2;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld_o  <= 1'b0;
         out_bit_o  <= 1'b0;
         crc1_chk_o <= 1'b0;
         crc1_ok_o  <= 1'b0;
         crc2_chk_o <= 1'b0;
         crc2_ok_o  <= 1'b0;
         done_o     <= 1'b0;
      end else begin
         out_vld_o  <= pos_i.accept & ~is_chk;
         if (pos_i.accept) begin
            out_bit_o <= data_i;
         end
         crc1_chk_o <= end1 & is_chk;
         crc2_chk_o <= end2 & is_chk;
         done_o     <= end2;
         if (end1 & is_chk) begin
            crc1_ok_o <= zero1_i;
         end else if (start_i) begin
            crc1_ok_o <= 1'b0;
         end
         if (end2 & is_chk) begin
            crc2_ok_o <= zero2_i;
         end else if (start_i) begin
            crc2_ok_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dual_crc_framer.sv
module dual_crc_framer
   import dcrc_pkg::*;
#(
   parameter int                 PAYLOAD_BITS = 192,
   parameter int                 CRC_W        = 16,
   parameter logic [CRC_W-1:0]   POLY_A       = 16'h8005,
   parameter logic [CRC_W-1:0]   POLY_B       = 16'h1021
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic mode_i,
   input  logic bit_valid_i,
   input  logic bit_i,
   output logic out_vld_o,
   output logic out_bit_o,
   output logic crc1_chk_o,
   output logic crc1_ok_o,
   output logic crc2_chk_o,
   output logic crc2_ok_o,
   output logic done_o
);
   localparam int N_LANES = 2;

   if (PAYLOAD_BITS < 1) begin : g_bad_payload
      $error("PAYLOAD_BITS must be at least 1");
   end
   if (CRC_W < 2) begin : g_bad_width
      $error("CRC_W must be at least 2");
   end
   if (POLY_A[0] != 1'b1 || POLY_B[0] != 1'b1) begin : g_bad_poly
      $error("checksum polynomials need a constant term");
   end

   dcrc_pos_t  pos;
   dcrc_mode_e mode_eff;
   logic       data;
   logic       lane_msb  [N_LANES];
   logic       lane_zero [N_LANES];

   dcrc_seq #(
      .PAYLOAD_BITS(PAYLOAD_BITS),
      .CRC_W       (CRC_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .mode_i     (mode_i),
      .bit_valid_i(bit_valid_i),
      .pos_o      (pos),
      .mode_o     (mode_eff)
   );

   // In generate mode the checksum fields are sourced from the lanes;
   // feeding a lane its own top bit turns it into a plain shift-out.
   always_comb begin
      data = bit_i;
      if (mode_eff == MODE_GEN) begin
         if (pos.in_f1) begin
            data = lane_msb[0];
         end else if (pos.in_f2) begin
            data = lane_msb[1];
         end
      end
   end

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam logic [CRC_W-1:0] LANE_POLY = (g == 0) ? POLY_A : POLY_B;
      logic lane_en;
      assign lane_en = (g == 0) ? (pos.accept & pos.cov1) : pos.accept;
      dcrc_lane #(
         .W   (CRC_W),
         .POLY(LANE_POLY)
      ) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .clear_i(start_i),
         .en_i   (lane_en),
         .data_i (data),
         .msb_o  (lane_msb[g]),
         .zero_o (lane_zero[g])
      );
   end

   dcrc_result u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .pos_i     (pos),
      .mode_i    (mode_eff),
      .data_i    (data),
      .zero1_i   (lane_zero[0]),
      .zero2_i   (lane_zero[1]),
      .out_vld_o (out_vld_o),
      .out_bit_o (out_bit_o),
      .crc1_chk_o(crc1_chk_o),
      .crc1_ok_o (crc1_ok_o),
      .crc2_chk_o(crc2_chk_o),
      .crc2_ok_o (crc2_ok_o),
      .done_o    (done_o)
   );

endmodule

// File: rtl/dcrc_checker.sv
module dcrc_checker (
   input logic clk,
   input logic rst_n,
   input logic bit_valid_i,
   input logic out_vld_o,
   input logic crc1_chk_o,
   input logic crc2_chk_o,
   input logic done_o
);
   // R6: the second result always coincides with end of frame
   a_r6_chk2_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      crc2_chk_o |-> done_o);

   // R5: the two field results never share a cycle
   a_r5_one_field_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({crc1_chk_o, crc2_chk_o}));

   // R7: done lasts a single cycle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4: an output bit only follows an input bit
   a_r4_out_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |-> $past(bit_valid_i));

   // R4: the output stream and check results belong to different modes
   a_r4_stream_excl_results: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |-> !(crc1_chk_o || crc2_chk_o));

   // R9: a first-field result needs a bit accepted the cycle before
   a_r9_chk1_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      crc1_chk_o |-> $past(bit_valid_i));

   // R7: end of frame needs a bit accepted the cycle before
   a_r7_done_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(bit_valid_i));

endmodule

bind dual_crc_framer dcrc_checker u_dcrc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_valid_i(bit_valid_i),
   .out_vld_o  (out_vld_o),
   .crc1_chk_o (crc1_chk_o),
   .crc2_chk_o (crc2_chk_o),
   .done_o     (done_o)
);

// File: tb/dual_crc_framer_bench.sv
`timescale 1ns/1ps
module dual_crc_framer_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic mode_i = 1'b0;
   logic bit_valid_i = 1'b0;
   logic bit_i = 1'b0;
   logic out_vld_o, out_bit_o, crc1_chk_o, crc1_ok_o, crc2_chk_o, crc2_ok_o, done_o;

   dual_crc_framer u_dual_crc_framer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .bit_valid_i(bit_valid_i), .bit_i(bit_i),
      .out_vld_o(out_vld_o), .out_bit_o(out_bit_o),
      .crc1_chk_o(crc1_chk_o), .crc1_ok_o(crc1_ok_o),
      .crc2_chk_o(crc2_chk_o), .crc2_ok_o(crc2_ok_o), .done_o(done_o)
   );

   always #5 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // observation at falling edges
   logic [223:0] cap;
   int ncap, n1, n2, nd, s1, s2, sd, t1, t2;
   logic r1, r2;
   always @(negedge clk) begin
      if (out_vld_o) begin cap = {cap[222:0], out_bit_o}; ncap++; end
      if (crc1_chk_o) begin n1++; s1 = cyc; r1 = crc1_ok_o; end
      if (crc2_chk_o) begin n2++; s2 = cyc; r2 = crc2_ok_o; end
      if (done_o) begin nd++; sd = cyc; end
   end

   task automatic check(input bit cond, input string tag,
                        input logic [223:0] act, input logic [223:0] exp);
      n_checks++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // remainder of data(x)*x^16 modulo g(x), by long division
   function automatic logic [15:0] rem(input logic [223:0] v, input int nbits,
                                       input logic [16:0] g);
      logic [239:0] w;
      logic [15:0] r;
      w = '0;
      for (int k = 0; k < nbits; k++) w[239-k] = v[223-k];
      for (int k = 0; k < nbits; k++)
         if (w[239-k])
            for (int j = 0; j <= 16; j++) w[239-k-j] = w[239-k-j] ^ g[16-j];
      for (int j = 0; j < 16; j++) r[15-j] = w[239-nbits-j];
      return r;
   endfunction

   function automatic logic [223:0] build(input logic [191:0] p);
      logic [223:0] v;
      v = {p, 32'h0};
      v[31:16] = rem(v, 192, 17'h18005);
      v[15:0]  = rem(v, 208, 17'h11021);
      return v;
   endfunction

   task automatic clear_obs();
      @(posedge clk);
      ncap = 0; cap = '0; n1 = 0; n2 = 0; nd = 0;
      s1 = -1; s2 = -1; sd = -1; t1 = -2; t2 = -2;
   endtask

   task automatic drive(input logic [223:0] v, input logic md, input int nbits,
                        input int gap, input bit toggle);
      for (int k = 0; k < nbits; k++) begin
         if (gap != 0 && k != 0 && k % gap == 0) begin
            @(negedge clk); bit_valid_i = 0; start_i = 0; bit_i = 1'b1;
         end
         @(negedge clk);
         start_i = (k == 0);
         bit_valid_i = 1'b1;
         bit_i = (md == 1'b0 && k >= 192) ? ~v[223-k] : v[223-k];
         mode_i = (toggle && k > 3) ? ~md : md;
         if (k == 207) t1 = cyc;
         if (k == 223) t2 = cyc;
      end
      @(negedge clk); start_i = 0; bit_valid_i = 0; bit_i = 0; mode_i = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic gen_frame(input logic [191:0] p, input int gap, input bit toggle);
      logic [223:0] v;
      v = build(p);
      clear_obs();
      drive(v, 1'b0, 224, gap, toggle);
      check(ncap == 224, "R4 output bit count", ncap, 224);
      check(cap[223:32] == v[223:32], "R4 payload echo", cap[223:32], v[223:32]);
      check(cap[31:16] == v[31:16], "R2 first checksum", cap[31:16], v[31:16]);
      check(cap[15:0] == v[15:0], "R3 second checksum", cap[15:0], v[15:0]);
      check(nd == 1 && sd == t2 + 1, "R7 done timing", sd, t2 + 1);
      check(n1 == 0 && n2 == 0, "R4 no results in generate", n1 + n2, 0);
   endtask

   task automatic chk_frame(input logic [223:0] v, input int gap, input bit toggle);
      logic e1, e2;
      e1 = (rem(v, 192, 17'h18005) == v[31:16]);
      e2 = (rem(v, 208, 17'h11021) == v[15:0]);
      clear_obs();
      drive(v, 1'b1, 224, gap, toggle);
      check(n1 == 1 && s1 == t1 + 1, "R5 result strobe timing", s1, t1 + 1);
      check(r1 == e1, "R5 first pass flag", r1, e1);
      check(crc1_ok_o == e1, "R5 pass flag held", crc1_ok_o, e1);
      check(n2 == 1 && s2 == t2 + 1, "R6 result strobe timing", s2, t2 + 1);
      check(r2 == e2, "R6 second pass flag", r2, e2);
      check(crc2_ok_o == e2, "R6 pass flag held", crc2_ok_o, e2);
      check(nd == 1 && sd == t2 + 1, "R7 done timing", sd, t2 + 1);
      check(ncap == 0, "R4 no stream in check", ncap, 0);
   endtask

   function automatic logic [191:0] lcg_payload(input logic [31:0] seed);
      logic [191:0] p;
      logic [31:0] s;
      s = seed;
      for (int i = 0; i < 6; i++) begin
         s = s * 32'd1664525 + 32'd1013904223;
         p[i*32 +: 32] = s;
      end
      return p;
   endfunction

   initial begin
      #(200000 * 10);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [223:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({out_vld_o, crc1_chk_o, crc1_ok_o, crc2_chk_o, crc2_ok_o, done_o} == 6'b0,
            "R1 reset outputs", {out_vld_o, crc1_chk_o, crc1_ok_o, crc2_chk_o, crc2_ok_o, done_o}, 0);

      // R1: bits before any start are ignored
      clear_obs();
      for (int k = 0; k < 240; k++) begin
         @(negedge clk); bit_valid_i = 1'b1; bit_i = k[0];
      end
      @(negedge clk); bit_valid_i = 0;
      repeat (3) @(negedge clk);
      check(ncap == 0 && nd == 0 && n1 == 0, "R1 idle ignores bits", ncap + nd + n1, 0);

      // R2 R3 R4 R7: generate under several payloads
      gen_frame('0, 0, 0);
      gen_frame('1, 0, 0);
      gen_frame({24{8'hA5}}, 0, 0);
      for (int s = 1; s <= 4; s++) gen_frame(lcg_payload(s * 77), 0, 0);
      // R9: gaps in the stream
      gen_frame(lcg_payload(991), 7, 0);
      // R10: mode toggling mid-frame ignored
      gen_frame(lcg_payload(313), 0, 1);

      // R5 R6: good frames
      chk_frame(build('0), 0, 0);
      chk_frame(build({24{8'h3C}}), 0, 0);
      for (int s = 1; s <= 3; s++) chk_frame(build(lcg_payload(s * 501)), 0, 0);
      chk_frame(build(lcg_payload(42)), 5, 0);
      chk_frame(build(lcg_payload(43)), 0, 1);
      // R5 R6: single-bit corruptions in each field
      v = build(lcg_payload(7)); v[100] = ~v[100]; chk_frame(v, 0, 0);
      v = build(lcg_payload(8)); v[20]  = ~v[20];  chk_frame(v, 0, 0);
      v = build(lcg_payload(9)); v[3]   = ~v[3];   chk_frame(v, 0, 0);
      v = build(lcg_payload(10)); v[223] = ~v[223]; chk_frame(v, 0, 0);

      // R8: abort mid-frame, then a full good frame
      clear_obs();
      drive(~build(lcg_payload(55)), 1'b1, 150, 0, 0);
      check(n1 == 0 && nd == 0, "R8 aborted frame silent", n1 + nd, 0);
      chk_frame(build(lcg_payload(56)), 0, 0);
      clear_obs();
      drive(build(lcg_payload(57)), 1'b0, 100, 0, 0);
      gen_frame(lcg_payload(58), 0, 0);

      // R9: bits after the frame are ignored and flags keep their values
      chk_frame(build(lcg_payload(60)), 0, 0);
      clear_obs();
      for (int k = 0; k < 60; k++) begin
         @(negedge clk); bit_valid_i = 1'b1; bit_i = ~k[1];
      end
      @(negedge clk); bit_valid_i = 0;
      repeat (3) @(negedge clk);
      check(ncap == 0 && nd == 0 && n1 == 0 && n2 == 0, "R9 post-frame bits ignored",
            ncap + nd + n1 + n2, 0);
      check(crc1_ok_o && crc2_ok_o, "R9 flags unchanged", {crc1_ok_o, crc2_ok_o}, 2'b11);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule